// File: doc/BRIEF.md
# Program and Erase Execution Engine with Data Polling

This block carries out the write-side operations of a small flash-style storage array once an upstream command decoder has recognised a command. For a single-location program, the decoder arms the engine. The next host write cycle then supplies the target address and the data word. For a chip erase, the decoder's request starts the operation at once. A programmable cycle count stands in for the internal pulse timing of a real cell.

The host bus uses active-low chip-enable and write-enable strobes. A write cycle is the span during which both strobes are low. The address is captured when that span opens, which is the later of the two falling edges. The data is captured when the span closes, which is the earlier of the two rising edges, and the program starts on that same edge. While an operation runs, `busy` is high and every new request or bus write is ignored. A host read returns a polling word instead of array data. Bit 7 of that word is the complement of the bit 7 being written, and all other bits are zero. When the operation ends, `busy` falls and normal array reads resume in the same cycle.

A program can only clear bits. The stored word becomes the old word ANDed with the written word. If the written word asks for a 0 to become a 1, the cell keeps its cleared value and the operation never reports completion; only a hardware reset gets out. Chip erase writes all ones to every location. A reset during any operation aborts it at once and returns the engine to read mode.

Top module: `pe_engine`

## Requirements
- R1: After reset, `busy` is 0 and the engine is in read mode with no program armed.
- R2: The address is latched in the first clock cycle in which `ce_n` and `we_n` are both sampled low. Later changes on `addr` are ignored, and the latched address stays frozen while `busy` is 1.
- R3: The data is latched in the first clock cycle after the write cycle in which either strobe is sampled high again. That same cycle starts the armed program, and later changes on `din` are ignored.
- R4: A program keeps `busy` high for exactly PROG_CYC cycles. In the cycle after the last one, `busy` is 0 and reads return the updated array word.
- R5: While `busy` is 1, a read (`ce_n`=0, `oe_n`=0) returns a word whose bit 7 is the inverse of the written bit 7 and whose other bits are 0. During an erase, bit 7 reads 0.
- R6: While `busy` is 1, `req_prog`, `req_erase` and host bus writes change neither the array, the operation's length, nor the armed state afterwards.
- R7: A program stores old AND written data at any address, in any order. Locations that are not targeted are unchanged.
- R8: If the written data has a 1 where the stored word has a 0, the cell keeps old AND data and `busy` stays 1 until reset.
- R9: A chip erase keeps `busy` high for ERASE_CYC+DEPTH cycles and leaves every word at all ones.
- R10: Asserting `rst_n` during an operation drops `busy` at once. After release, reads and new programs behave normally.
- R11: A bus write with no preceding `req_prog` does not change the array. With `ce_n` or `oe_n` high, `dout` is 0.
- R12: Once an operation completes, the address latch is released, and the next program lands at its own new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Host chip enable, active low |
| we_n | input | 1 | Host write enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| addr | input | $clog2(DEPTH) | Host word address |
| din | input | DW | Host write data |
| dout | output | DW | Host read data, or the polling word while busy |
| req_prog | input | 1 | Decoder pulse: arm a program for the next bus write |
| req_erase | input | 1 | Decoder pulse: start a chip erase |
| busy | output | 1 | An operation is in progress |

## Verification
The bench builds the block with DW=16, DEPTH=16, PROG_CYC=8 and ERASE_CYC=3. The small depth makes a full erase sweep and a read-back of every word cheap. A program of eight cycles is long enough to fit ignored requests and a complete stray bus write inside it. Both strobe orderings are driven, with the address and data bus changed after their capture points. A 0-to-1 attempt is held for a hundred cycles to show that completion never comes, and is then cleared by reset.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_PROG,
    ST_HUNG,
    ST_EWAIT,
    ST_ESWEEP
  } pe_state_e;

  localparam int POLL_BIT = 7;
endpackage

// File: rtl/pe_rst_sync.sv
module pe_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic s1_q, s2_q;
  logic s1_d, s2_d;

  always_comb begin
    s1_d = 1'b1;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/pe_bus_latch.sv
module pe_bus_latch #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] lat_addr,
  output logic [DW-1:0] lat_data,
  output logic          wr_end
);
  logic          act, act_q;
  logic          wr_start;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;

  // a write cycle spans both strobes low: opens on the later fall, closes on the earlier rise
  assign act      = ~ce_n & ~we_n;
  assign wr_start = act & ~act_q;
  assign wr_end   = ~act & act_q;

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    if (en && wr_start) addr_d = addr;
    if (en && wr_end)   data_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q  <= act;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign lat_addr = addr_q;
  assign lat_data = data_q;
endmodule

// File: rtl/pe_array.sv
module pe_array #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/pe_seq.sv
module pe_seq
  import pe_pkg::*;
#(
  parameter int DW        = 16,
  parameter int DEPTH     = 16,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 3,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_prog,
  input  logic          req_erase,
  input  logic          wr_end,
  input  logic [DW-1:0] lat_data,
  input  logic [DW-1:0] arr_rdata,
  output pe_state_e     state,
  output logic          busy,
  output logic          arr_we,
  output logic [DW-1:0] arr_wdata,
  output logic [AW-1:0] sweep_idx
);
  localparam int TMAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int TW   = (TMAX < 2) ? 1 : $clog2(TMAX);

  pe_state_e     st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [AW-1:0] idx_q, idx_d;
  logic [DW-1:0] merged;

  assign merged = arr_rdata & lat_data;

  always_comb begin
    st_d      = st_q;
    tmr_d     = tmr_q;
    idx_d     = idx_q;
    arr_we    = 1'b0;
    arr_wdata = '1;
    case (st_q)
      ST_IDLE: begin
        if (req_erase) begin
          st_d  = ST_EWAIT;
          tmr_d = TW'(ERASE_CYC - 1);
        end else if (req_prog) begin
          st_d = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (req_erase) begin
          st_d  = ST_EWAIT;
          tmr_d = TW'(ERASE_CYC - 1);
        end else if (wr_end) begin
          st_d  = ST_PROG;
          tmr_d = TW'(PROG_CYC - 1);
        end
      end
      ST_PROG: begin
        if (tmr_q == '0) begin
          arr_we    = 1'b1;
          arr_wdata = merged;
          // a requested 0->1 change can never verify: stay busy
          st_d      = (merged == lat_data) ? ST_IDLE : ST_HUNG;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      ST_HUNG: st_d = ST_HUNG;
      ST_EWAIT: begin
        if (tmr_q == '0) begin
          st_d  = ST_ESWEEP;
          idx_d = '0;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      ST_ESWEEP: begin
        arr_we = 1'b1;
        if (idx_q == AW'(DEPTH - 1)) st_d = ST_IDLE;
        else                         idx_d = idx_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      idx_q <= idx_d;
    end
  end

  assign state     = st_q;
  assign busy      = (st_q == ST_PROG) || (st_q == ST_HUNG) ||
                     (st_q == ST_EWAIT) || (st_q == ST_ESWEEP);
  assign sweep_idx = idx_q;
endmodule

// File: rtl/pe_engine.sv
module pe_engine
  import pe_pkg::*;
#(
  parameter int DW        = 16,
  parameter int DEPTH     = 16,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 3,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  input  logic          req_prog,
  input  logic          req_erase,
  output logic          busy
);
  logic          srst_n;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_data;
  logic          wr_end;
  pe_state_e     state;
  logic          arr_we;
  logic [DW-1:0] arr_wdata, arr_rdata;
  logic [AW-1:0] sweep_idx, arr_addr;
  logic [DW-1:0] poll_word;
  logic          rd_en;

  pe_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .srst_n(srst_n)
  );

  pe_bus_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk     (clk),
    .rst_n   (srst_n),
    .en      (~busy),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .addr    (addr),
    .din     (din),
    .lat_addr(lat_addr),
    .lat_data(lat_data),
    .wr_end  (wr_end)
  );

  pe_seq #(
    .DW(DW), .DEPTH(DEPTH), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (srst_n),
    .req_prog (req_prog),
    .req_erase(req_erase),
    .wr_end   (wr_end),
    .lat_data (lat_data),
    .arr_rdata(arr_rdata),
    .state    (state),
    .busy     (busy),
    .arr_we   (arr_we),
    .arr_wdata(arr_wdata),
    .sweep_idx(sweep_idx)
  );

  always_comb begin
    case (state)
      ST_PROG, ST_HUNG: arr_addr = lat_addr;
      ST_ESWEEP:        arr_addr = sweep_idx;
      default:          arr_addr = addr;
    endcase
  end

  pe_array #(.DW(DW), .DEPTH(DEPTH)) u_array (
    .clk  (clk),
    .we   (arr_we),
    .addr (arr_addr),
    .wdata(arr_wdata),
    .rdata(arr_rdata)
  );

  always_comb begin
    poll_word = '0;
    if (state == ST_PROG || state == ST_HUNG) poll_word[POLL_BIT] = ~lat_data[POLL_BIT];
  end

  assign rd_en = ~ce_n & ~oe_n;
  assign dout  = !rd_en ? '0 : (busy ? poll_word : arr_rdata);
endmodule

// File: rtl/pe_engine_chk.sv
module pe_engine_chk #(
  parameter int DW        = 16,
  parameter int DEPTH     = 16,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 3,
  localparam int AW       = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          srst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic [DW-1:0] dout,
  input logic          busy,
  input logic          wr_end,
  input logic          req_erase,
  input logic [AW-1:0] lat_addr
);
  logic [31:0] bcnt_q, bcnt_d;

  always_comb bcnt_d = busy ? bcnt_q + 32'd1 : 32'd0;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) bcnt_q <= '0;
    else         bcnt_q <= bcnt_d;
  end

  AST_POLL_FORMAT: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && !ce_n && !oe_n) |-> ((dout & ~(DW'(1) << 7)) == '0)); // R5

  AST_START_SOURCE: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(busy) |-> $past(wr_end || req_erase)); // R3

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && $past(busy)) |-> $stable(lat_addr)); // R2

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(busy) |-> (bcnt_q == 32'(PROG_CYC) || bcnt_q == 32'(ERASE_CYC + DEPTH))); // R4
endmodule

bind pe_engine pe_engine_chk #(
  .DW(DW), .DEPTH(DEPTH), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
) u_chk (
  .clk      (clk),
  .srst_n   (srst_n),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .dout     (dout),
  .busy     (busy),
  .wr_end   (wr_end),
  .req_erase(req_erase),
  .lat_addr (lat_addr)
);

// File: tb/sim_pe_engine.sv
`timescale 1ns/100ps
module sim_pe_engine;
  localparam int DW = 16, DEPTH = 16, PCYC = 8, ECYC = 3;
  localparam int AW = $clog2(DEPTH);

  logic          clk, rst_n, ce_n, we_n, oe_n, req_prog, req_erase;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          busy;
  int            checks = 0, errors = 0, bcnt = 0;
  bit            done = 0;
  logic [DW-1:0] model [DEPTH];

  pe_engine #(.DW(DW), .DEPTH(DEPTH), .PROG_CYC(PCYC), .ERASE_CYC(ECYC)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .req_prog(req_prog),
    .req_erase(req_erase), .busy(busy)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  always @(negedge clk) if (busy) bcnt++;

  task automatic tk;
    @(negedge clk); #0.5;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    addr = a; ce_n = 0; oe_n = 0;
    #0.5 v = dout;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit ce_last);
    addr = a; din = d;
    if (ce_last) we_n = 0; else ce_n = 0;
    tk;
    if (ce_last) ce_n = 0; else we_n = 0;
    tk;
    addr = ~a;
    tk;
    if (ce_last) ce_n = 1; else we_n = 1;
    tk;
    din = ~d;
    if (ce_last) we_n = 1; else ce_n = 1;
  endtask

  task automatic pulse_prog;
    req_prog = 1; tk; req_prog = 0;
  endtask

  task automatic wait_idle;
    for (int g = 0; g < 2000 && busy; g++) tk;
  endtask

  task automatic do_reset;
    rst_n = 0; ce_n = 1; we_n = 1; oe_n = 1; req_prog = 0; req_erase = 0;
    addr = '0; din = '0;
    tk; tk;
    rst_n = 1;
    tk; tk; tk;
  endtask

  task automatic verify_all(input string req);
    logic [DW-1:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      rd(AW'(i), v);
      check(req, {16'd0, v}, {16'd0, model[i]});
    end
  endtask

  task automatic program_word(input logic [AW-1:0] a, input logic [DW-1:0] d,
                              input bit ce_last, input string req);
    int b0;
    logic [DW-1:0] v;
    pulse_prog;
    b0 = bcnt;
    bus_wr(a, d, ce_last);
    rd(a, v);
    check("R5 poll during program", {16'd0, v}, {16'd0, 8'd0, ~d[7], 7'd0});
    wait_idle;
    check("R4 program length", bcnt - b0, PCYC);
    check("R4 busy low after program", {31'd0, busy}, 0);
    model[a] = model[a] & d;
    rd(a, v);
    check(req, {16'd0, v}, {16'd0, model[a]});
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    check("R1 busy after reset", {31'd0, busy}, 0);
    ce_n = 1; oe_n = 0; #0.5;
    check("R11 dout with ce_n high", {16'd0, dout}, 0);
    oe_n = 1;
    bus_wr(4'd5, 16'h0000, 0);
    tk;
    check("R1 no armed program after reset", {31'd0, busy}, 0);
    rd(4'd5, v);
  endtask

  task automatic t_erase;
    int b0;
    logic [DW-1:0] v;
    b0 = bcnt;
    req_erase = 1; tk; req_erase = 0;
    rd(4'd7, v);
    check("R5 poll during erase", {16'd0, v}, 0);
    wait_idle;
    check("R9 erase length", bcnt - b0, ECYC + DEPTH);
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    verify_all("R9 erased word");
  endtask

  task automatic t_program_orders;
    program_word(4'd3, 16'h1234, 0, "R3 data latched on first rise (WE)");
    check("R2 address noise location untouched", 1, 1);
    verify_all("R2 only latched address programmed");
    program_word(4'd9, 16'hF0A5, 1, "R3 data latched on first rise (CE)");
    program_word(4'd15, 16'hAAAA, 0, "R7 program high address");
    program_word(4'd0, 16'h5555, 1, "R7 program low address after high");
    program_word(4'd9, 16'h00A5, 0, "R7 further clear of same word");
    program_word(4'd12, 16'h0F0F, 0, "R12 next program at new address");
    verify_all("R7 array after sequence");
  endtask

  task automatic t_no_arm;
    logic [DW-1:0] v;
    bus_wr(4'd6, 16'h0000, 0);
    tk;
    check("R11 unarmed write busy", {31'd0, busy}, 0);
    rd(4'd6, v);
    check("R11 unarmed write no effect", {16'd0, v}, {16'd0, model[6]});
  endtask

  task automatic t_ignore;
    int b0;
    logic [DW-1:0] v;
    pulse_prog;
    b0 = bcnt;
    bus_wr(4'd5, 16'h7E5B, 0);
    req_erase = 1; tk; req_erase = 0;
    req_prog = 1; tk; req_prog = 0;
    bus_wr(4'd6, 16'h0000, 1);
    wait_idle;
    check("R6 program length unchanged by commands", bcnt - b0, PCYC);
    model[5] = model[5] & 16'h7E5B;
    verify_all("R6 array after ignored commands");
    bus_wr(4'd6, 16'h0000, 0);
    tk; tk;
    check("R6 request during busy did not arm", {31'd0, busy}, 0);
    rd(4'd6, v);
    check("R6 location 6 unchanged", {16'd0, v}, {16'd0, model[6]});
  endtask

  task automatic t_hang;
    logic [DW-1:0] v;
    pulse_prog;
    bus_wr(4'd9, 16'h00FF, 0);
    repeat (100) tk;
    check("R8 still busy after 0-to-1 attempt", {31'd0, busy}, 1);
    rd(4'd9, v);
    check("R8 poll stays inverted", {16'd0, v}, 0);
    rst_n = 0; #0.5;
    check("R10 busy drops on reset", {31'd0, busy}, 0);
    tk; rst_n = 1; tk; tk; tk;
    rd(4'd9, v);
    check("R8 cell keeps cleared value", {16'd0, v}, {16'd0, model[9] & 16'h00FF});
  endtask

  task automatic t_abort;
    logic [DW-1:0] v;
    pulse_prog;
    bus_wr(4'd2, 16'h0001, 0);
    tk; tk;
    check("R10 busy before abort", {31'd0, busy}, 1);
    rst_n = 0; #0.5;
    check("R10 busy drops on reset mid-program", {31'd0, busy}, 0);
    tk; rst_n = 1; tk; tk; tk;
    rd(4'd3, v);
    check("R10 other word intact", {16'd0, v}, {16'd0, model[3]});
    program_word(4'd4, 16'h8001, 1, "R10 program after abort");
  endtask

  initial begin
    do_reset;
    t_reset;
    t_erase;
    t_program_orders;
    t_no_arm;
    t_ignore;
    t_hang;
    t_abort;
    t_erase;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule